// File: doc/BRIEF.md
# Seven-to-one flat-panel serializer

This block turns one parallel display word per pixel period into serial streams for a flat-panel link. Each pixel word has 28 signals: 8 bits each of red, green and blue, plus horizontal sync, vertical sync, data-valid and one spare control bit. The block spreads these signals over four data lanes. Each lane sends seven bits per pixel period. A fifth lane carries a framing pattern at the pixel rate, so a receiver can find where each pixel starts.

The block runs on one fast clock. A bit-advance strobe, `bit_en`, marks each serial bit time; it comes from an external frequency multiplier. Holding `bit_en` high runs the block with the fast clock as the 7x bit clock. The parallel inputs are sampled once per pixel period, on the last bit time of the current period. They are then sent during the next seven bit times, so a pixel appears on the lanes one pixel period after it is captured. Pad drivers, termination and the multiplier are outside this block.

Top module: `fpd_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every data lane is 0 after that edge and the clock lane is 1. The first seven bit times after reset carry all-zero data.
- R2: The clock lane repeats the pattern 1,1,0,0,0,1,1, one value per bit time. It starts with the first value in the first bit time after reset.
- R3: Lane 0 (`data_lane[0]`) sends, first to last: green0, red5, red4, red3, red2, red1, red0.
- R4: Lane 1 (`data_lane[1]`) sends, first to last: blue1, blue0, green5, green4, green3, green2, green1.
- R5: Lane 2 (`data_lane[2]`) sends, first to last: de, vsync, hsync, blue5, blue4, blue3, blue2.
- R6: Lane 3 (`data_lane[3]`) sends, first to last: ctrl, blue7, blue6, green7, green6, red7, red6.
- R7: The parallel inputs are sampled only at the edge where `bit_en` is high and the seventh bit of a pixel period is being sent. The sampled pixel is sent in the following pixel period. Input values present at other times have no effect on the lanes.
- R8: While `bit_en` is low, all five lane outputs hold their values.
- R9: A reset asserted in the middle of a pixel period discards the pixel being sent and restarts the clock-lane pattern at its first value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; every register samples on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Advances the serial streams by one bit time |
| red | input | 8 | Red component of the pixel |
| green | input | 8 | Green component of the pixel |
| blue | input | 8 | Blue component of the pixel |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data valid |
| ctrl | input | 1 | Spare control bit |
| data_lane | output | 4 | Serial data, one bit per lane |
| clk_lane | output | 1 | Framing pattern lane |

## Verification
The bench builds the block with its default parameters: seven bits per lane, four data lanes and the 1100011 framing pattern. These defaults give the full 28-signal slot map, so every pixel field can be traced to its lane and bit slot. Walking-one pixels, complementary pixels and stalled runs with `bit_en` pulsed every few cycles exercise both the slot map and the hold behaviour. Input changes just before the capture bit, and a reset in the middle of a pixel period, exercise the capture boundary and the restart of the pattern.

// File: rtl/fpd_ser_pkg.sv
// Shared constants and the pixel word type for the flat-panel serializer.
// Assumes a fixed slot map of 4 data lanes by 7 bits per lane.
package fpd_ser_pkg;
    localparam int LANE_BITS  = 7;
    localparam int DATA_LANES = 4;
    localparam logic [LANE_BITS-1:0] CLK_PATTERN_DEF = 7'b1100011;

    typedef struct packed {
        logic       ctrl;
        logic       de;
        logic       vsync;
        logic       hsync;
        logic [7:0] blu;
        logic [7:0] grn;
        logic [7:0] red;
    } pixel_t;

    typedef logic [LANE_BITS-1:0] lane_word_t;
endpackage

// File: rtl/fpd_slot_counter.sv
// Counts bit slots within one pixel period, wrapping after SLOTS bits.
// Assumes bit_en marks each serial bit time; synchronous active-low reset.
module fpd_slot_counter #(
    parameter int SLOTS = 7,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    output logic [SW-1:0] slot,
    output logic          last_slot
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    assign last_slot = (slot == LAST);

    // Advance the slot index once per bit time and wrap at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (bit_en) begin
            slot <= last_slot ? '0 : slot + SW'(1);
        end
    end
endmodule

// File: rtl/fpd_lane_mapper.sv
// Spreads one pixel word over the data lanes in the fixed slot map.
// Bit LANE_BITS-1 of each lane word is the first bit transmitted.
module fpd_lane_mapper
    import fpd_ser_pkg::*;
(
    input  pixel_t     pix,
    output lane_word_t lane_word [DATA_LANES]
);
    // Place each pixel field in its lane and slot.
    always_comb begin
        lane_word[0] = {pix.grn[0], pix.red[5], pix.red[4], pix.red[3],
                        pix.red[2], pix.red[1], pix.red[0]};
        lane_word[1] = {pix.blu[1], pix.blu[0], pix.grn[5], pix.grn[4],
                        pix.grn[3], pix.grn[2], pix.grn[1]};
        lane_word[2] = {pix.de, pix.vsync, pix.hsync, pix.blu[5],
                        pix.blu[4], pix.blu[3], pix.blu[2]};
        lane_word[3] = {pix.ctrl, pix.blu[7], pix.blu[6], pix.grn[7],
                        pix.grn[6], pix.red[7], pix.red[6]};
    end
endmodule

// File: rtl/fpd_lane_shifter.sv
// Holds one lane word and sends it MSB first, one bit per bit time.
// Loads a new word on the bit time that sends the period's last bit.
module fpd_lane_shifter #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             load,
    input  logic [WIDTH-1:0] word,
    output logic             ser
);
    logic [WIDTH-1:0] shreg;

    assign ser = shreg[WIDTH-1];

    // Reload at the period boundary, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (bit_en) begin
            shreg <= load ? word : {shreg[WIDTH-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/fpd_clk_lane_gen.sv
// Selects the framing-pattern bit for the current slot, MSB at slot 0.
// Assumes slot never exceeds SLOTS-1.
module fpd_clk_lane_gen #(
    parameter int SLOTS = 7,
    parameter logic [SLOTS-1:0] PATTERN = 7'b1100011,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic [SW-1:0] slot,
    output logic          bit_out
);
    logic [SW-1:0] idx;

    // Map slot 0 to the pattern MSB.
    always_comb begin
        idx     = SW'(SLOTS - 1) - slot;
        bit_out = PATTERN[idx];
    end
endmodule

// File: rtl/fpd_serializer.sv
// Seven-to-one flat-panel serializer: captures a 28-signal pixel word once
// per pixel period and sends it on four data lanes plus a framing lane.
// Assumes bit_en marks serial bit times of an external 7x clock.
module fpd_serializer
    import fpd_ser_pkg::*;
#(
    parameter logic [LANE_BITS-1:0] CLK_PATTERN = CLK_PATTERN_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic [7:0]            red,
    input  logic [7:0]            green,
    input  logic [7:0]            blue,
    input  logic                  hsync,
    input  logic                  vsync,
    input  logic                  de,
    input  logic                  ctrl,
    output logic [DATA_LANES-1:0] data_lane,
    output logic                  clk_lane
);
    localparam int SW = $clog2(LANE_BITS);

    pixel_t        pix;
    lane_word_t    lane_word [DATA_LANES];
    logic [SW-1:0] slot;
    logic          last_slot;

    // Gather the parallel inputs into one pixel word.
    always_comb begin
        pix = '{ctrl: ctrl, de: de, vsync: vsync, hsync: hsync,
                blu: blue, grn: green, red: red};
    end

    fpd_slot_counter #(.SLOTS(LANE_BITS)) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .slot      (slot),
        .last_slot (last_slot)
    );

    fpd_lane_mapper map_i (
        .pix       (pix),
        .lane_word (lane_word)
    );

    for (genvar ln = 0; ln < DATA_LANES; ln++) begin : g_lane
        fpd_lane_shifter #(.WIDTH(LANE_BITS)) shf_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .bit_en (bit_en),
            .load   (last_slot),
            .word   (lane_word[ln]),
            .ser    (data_lane[ln])
        );
    end

    fpd_clk_lane_gen #(.SLOTS(LANE_BITS), .PATTERN(CLK_PATTERN)) clkgen_i (
        .slot    (slot),
        .bit_out (clk_lane)
    );
endmodule

// File: rtl/fpd_serializer_checker.sv
// Property checker for the flat-panel serializer, bound to the top module.
// Keeps its own slot count of bit_en pulses since reset.
module fpd_serializer_checker #(
    parameter int LANE_BITS = 7,
    parameter int DATA_LANES = 4,
    parameter logic [LANE_BITS-1:0] CLK_PATTERN = 7'b1100011,
    localparam int SW = $clog2(LANE_BITS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bit_en,
    input logic [DATA_LANES-1:0] data_lane,
    input logic                  clk_lane
);
    logic [SW-1:0] chk_slot;
    logic          first_frame;
    logic [SW-1:0] pat_idx;

    // Independent slot count and first-period flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_slot    <= '0;
            first_frame <= 1'b1;
        end else if (bit_en) begin
            if (chk_slot == SW'(LANE_BITS - 1)) begin
                chk_slot    <= '0;
                first_frame <= 1'b0;
            end else begin
                chk_slot <= chk_slot + SW'(1);
            end
        end
    end

    assign pat_idx = SW'(LANE_BITS - 1) - chk_slot;

    assert_reset_lanes_zero_R1: assert property (@(posedge clk)
        !rst_n |=> data_lane == '0);

    assert_reset_clk_first_R9: assert property (@(posedge clk)
        !rst_n |=> clk_lane == CLK_PATTERN[LANE_BITS-1]);

    assert_first_period_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        first_frame |-> data_lane == '0);

    assert_clk_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lane == CLK_PATTERN[pat_idx]);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(data_lane) && $stable(clk_lane));
endmodule

bind fpd_serializer fpd_serializer_checker #(
    .LANE_BITS   (fpd_ser_pkg::LANE_BITS),
    .DATA_LANES  (fpd_ser_pkg::DATA_LANES),
    .CLK_PATTERN (CLK_PATTERN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .data_lane (data_lane),
    .clk_lane  (clk_lane)
);

// File: tb/fpd_serializer_tb_top.sv
// Directed bench for the flat-panel serializer; one task per scenario.
module fpd_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [7:0] red = '0, green = '0, blue = '0;
    logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0, ctrl = 1'b0;
    logic [3:0] data_lane;
    logic       clk_lane;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [27:0] cur_pix = '0;   // pixel being sent: {ctrl,de,vs,hs,b,g,r}

    localparam logic [6:0] PAT = 7'b1100011;

    always #5 clk = ~clk;

    fpd_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .red(red), .green(green), .blue(blue),
        .hsync(hsync), .vsync(vsync), .de(de), .ctrl(ctrl),
        .data_lane(data_lane), .clk_lane(clk_lane)
    );

    function automatic logic [6:0] lane_exp(logic [27:0] p, int ln);
        logic [7:0] r, g, b;
        r = p[7:0]; g = p[15:8]; b = p[23:16];
        case (ln)
            0: return {g[0], r[5], r[4], r[3], r[2], r[1], r[0]};
            1: return {b[1], b[0], g[5], g[4], g[3], g[2], g[1]};
            2: return {p[26], p[25], p[24], b[5], b[4], b[3], b[2]};
            default: return {p[27], b[7], b[6], g[7], g[6], r[7], r[6]};
        endcase
    endfunction

    task automatic check_bit(logic got, logic exp, string req, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic apply_pix(logic [27:0] p);
        {ctrl, de, vsync, hsync, blue, green, red} = p;
    endtask

    // Compare all five lanes against slot b of pixel p.
    task automatic check_slot(logic [27:0] p, int b, string over);
        string lreq [4] = '{"R3", "R4", "R5", "R6"};
        for (int ln = 0; ln < 4; ln++) begin
            logic [6:0] w = lane_exp(p, ln);
            check_bit(data_lane[ln], w[6-b], (over != "") ? over : lreq[ln],
                      $sformatf("lane%0d slot%0d", ln, b));
        end
        check_bit(clk_lane, PAT[6-b], (over != "") ? over : "R2",
                  $sformatf("clk lane slot%0d", b));
    endtask

    // One pixel period: send cur_pix, offer nxt for capture at the last bit.
    task automatic run_frame(logic [27:0] nxt, int gap, bit late, string over);
        if (late) apply_pix(~nxt); else apply_pix(nxt);
        for (int b = 0; b < 7; b++) begin
            check_slot(cur_pix, b, over);
            for (int g = 0; g < gap; g++) begin
                bit_en = 1'b0;
                @(negedge clk);
                check_slot(cur_pix, b, "R8");
            end
            if (late && b == 6) apply_pix(nxt);
            bit_en = 1'b1;
            @(negedge clk);
        end
        cur_pix = nxt;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check_bit(data_lane == 4'b0, 1'b1, "R1", "data lanes in reset");
        check_bit(clk_lane, 1'b1, "R1", "clk lane in reset");
        rst_n = 1'b1;
        cur_pix = '0;
        run_frame(28'h5A3C_96E, 0, 1'b0, "R1");
    endtask

    task automatic test_stream();
        logic [27:0] pats [6] = '{28'hFFF_FFFF, 28'h0000001, 28'hAAA_AAAA,
                                  28'h555_5555, 28'h8000000, 28'h0000000};
        for (int i = 0; i < 6; i++) run_frame(pats[i], 0, 1'b0, "");
        for (int i = 0; i < 28; i++) run_frame(28'(1) << i, 0, 1'b0, "");
    endtask

    task automatic test_stall();
        run_frame(28'h1234567, 2, 1'b0, "");
        run_frame(28'hEDCBA98, 3, 1'b0, "");
    endtask

    task automatic test_late_change();
        run_frame(28'h0F0F0F0, 0, 1'b1, "R7");
        run_frame(28'h3C3C3C3, 0, 1'b1, "R7");
        run_frame(28'h0000000, 0, 1'b0, "R7");
    endtask

    task automatic test_mid_reset();
        apply_pix(28'hFFF_FFFF);
        for (int b = 0; b < 3; b++) begin
            check_slot(cur_pix, b, "");
            bit_en = 1'b1;
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_bit(data_lane == 4'b0, 1'b1, "R9", "data lanes after mid reset");
        check_bit(clk_lane, 1'b1, "R9", "clk lane after mid reset");
        rst_n = 1'b1;
        cur_pix = '0;
        run_frame(28'h2468ACE, 0, 1'b0, "R9");
        run_frame(28'h0, 0, 1'b0, "");
    endtask

    initial begin
        test_reset();
        test_stream();
        test_stall();
        test_late_change();
        test_mid_reset();
        bit_en = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule